// File: doc/BRIEF.md
# Two-Level Programmable Sample Pacer

This block produces the sample strobes that pace a parallel data port. A selectable prescaler divides the system clock into a base-rate tick. At the nominal setting this tick is 1 MHz. Every other interval in the block is a whole number of these ticks.

A 16-bit timing counter is loaded with a negative preset when the pacer is started. It advances once per base tick. When it climbs from all ones to zero, it emits a one-cycle overflow pulse and takes the preset again in the same cycle. A second counter counts these overflows and raises the sample strobe on every N-th one, where N is the dwell count.

Software starts the pacer with a one-cycle start pulse after it has set the rate code, preset and dwell inputs. This must happen before any transfer, including transfers that are paced by an external handshake. A stop pulse returns the pacer to idle. A preset that is not negative is refused and raises an error flag.

Top module: `sample_pacer`

## Requirements
- R1: While reset is applied, and after it is released, `running_o`, `tick_o`, `strobe_o` and `error_o` are all 0.
- R2: The rate code sets the system clocks per base tick: code 1 gives 1, code 2 gives 10, code 3 gives 100 and code 4 gives 1000. With code 0 or codes 5 to 7, no base tick is produced, so no tick or strobe appears even while running. The first base tick comes at the edge that lies one full ratio after the edge that samples start.
- R3: A valid start loads the preset, which must have bit 15 set. The first overflow comes at the edge `ratio*(65536-preset)` after the start edge. Overflows then repeat with that same period, so the reload loses no cycle. `tick_o` is 1 only while `running_o` is 1.
- R4: `tick_o` is high for the one cycle after each overflow edge and low in every other cycle.
- R5: `strobe_o` rises together with every D-th `tick_o`, counting from the start, where D is the dwell value. A dwell of 0 acts as 1. `strobe_o` is never high without `tick_o`.
- R6: A start pulse while idle, with preset bit 15 clear (zero or positive), leaves the pacer idle and sets `error_o` at the next edge.
- R7: A stop sampled at an edge clears `running_o` at that edge. No tick or strobe appears from that edge on. Stop takes priority over a start in the same cycle.
- R8: While running, the pacer ignores start pulses and changes to rate, preset and dwell. It keeps running with the values it captured at start.
- R9: A valid start clears `error_o` at the edge that samples it, and running begins at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Prescaler ratio code |
| preset | input | 16 | Negative reload value, two's complement |
| dwell | input | 16 | Overflows per sample strobe, 0 treated as 1 |
| start | input | 1 | One-cycle start request |
| stop | input | 1 | One-cycle stop request |
| tick_o | output | 1 | One-cycle pulse per timing-counter overflow |
| strobe_o | output | 1 | One-cycle sample strobe |
| running_o | output | 1 | Pacer active |
| error_o | output | 1 | Last start refused because of a bad preset |

## Verification
Each fault inside the pacer shows up at the ports in its own way:
- A prescaler that counts wrong, or decodes the wrong code, moves the first `tick_o` away from its predicted edge. The move is by whole ratios, and it is visible at the first overflow.
- A reload that slips by one cycle stretches the second overflow period. A test with a preset of -1 exposes this within a few cycles.
- A dwell counter that is off by one places `strobe_o` on the wrong overflow.
- A stop or start path that is broken shows up in the very next cycle's `running_o` and `error_o`.

The bench predicts every output in every cycle of each run, so any of these faults is reported at the first cycle it touches.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int RATE_W    = 3;
  localparam int NUM_RATES = 4;
  localparam int CNT_W     = 16;
  localparam int DWELL_W   = 16;
endpackage

// File: rtl/rate_divider.sv
module rate_divider
  import pacer_pkg::*;
#(
  parameter int RATIO_A = 1,
  parameter int RATIO_B = 10,
  parameter int RATIO_C = 100,
  parameter int RATIO_D = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [RATE_W-1:0] code,
  output logic              base_tick
);
  localparam int RATIO_AB  = (RATIO_A > RATIO_B) ? RATIO_A : RATIO_B;
  localparam int RATIO_CD  = (RATIO_C > RATIO_D) ? RATIO_C : RATIO_D;
  localparam int RATIO_MAX = (RATIO_AB > RATIO_CD) ? RATIO_AB : RATIO_CD;
  localparam int DIV_W     = (RATIO_MAX > 1) ? $clog2(RATIO_MAX) : 1;
  localparam int RATIOS [NUM_RATES] = '{RATIO_A, RATIO_B, RATIO_C, RATIO_D};

  logic [DIV_W-1:0]     cnt_q, cnt_d;
  logic [NUM_RATES-1:0] code_ok;
  logic [NUM_RATES-1:0] at_end;

  // One decode slice per selectable ratio; code g+1 picks slice g.
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_ratio
    assign code_ok[g] = (code == RATE_W'(g + 1));
    assign at_end[g]  = code_ok[g] && (cnt_q == DIV_W'(RATIOS[g] - 1));
  end

  assign base_tick = en && (|at_end);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en && (|code_ok)) begin
      cnt_d = base_tick ? '0 : cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/preset_counter.sv
module preset_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic         ovf
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] reload_q, reload_d;

  // Overflow: the step that carries the count from all ones to zero.
  assign ovf = step && (&cnt_q);

  always_comb begin
    cnt_d    = cnt_q;
    reload_d = reload_q;
    if (load) begin
      cnt_d    = load_val;
      reload_d = load_val;
    end else if (step) begin
      cnt_d = ovf ? reload_q : cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
    end
  end
endmodule

// File: rtl/dwell_counter.sv
module dwell_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit_in,
  input  logic         ovf,
  output logic         fire
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] lim_q, lim_d;

  assign fire = ovf && (cnt_q == lim_q - W'(1));

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (clr) begin
      cnt_d = '0;
      lim_d = (limit_in == '0) ? W'(1) : limit_in;
    end else if (ovf) begin
      cnt_d = fire ? '0 : cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= W'(1);
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end
endmodule

// File: rtl/sample_pacer.sv
module sample_pacer
  import pacer_pkg::*;
#(
  parameter int RATIO_A = 1,
  parameter int RATIO_B = 10,
  parameter int RATIO_C = 100,
  parameter int RATIO_D = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATE_W-1:0]  rate_sel,
  input  logic [CNT_W-1:0]   preset,
  input  logic [DWELL_W-1:0] dwell,
  input  logic               start,
  input  logic               stop,
  output logic               tick_o,
  output logic               strobe_o,
  output logic               running_o,
  output logic               error_o
);
  logic              rst_meta_q, rst_sync_n;
  logic              running_q, running_d;
  logic              error_q, error_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              tick_q, tick_d;
  logic              strobe_q, strobe_d;
  logic              start_ok, start_bad;
  logic              active, base_tick, ovf, fire;

  // Reset is asserted asynchronously and released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign start_ok  = start && !stop && !running_q &&  preset[CNT_W-1];
  assign start_bad = start && !stop && !running_q && !preset[CNT_W-1];
  assign active    = running_q && !stop;

  rate_divider #(
    .RATIO_A(RATIO_A), .RATIO_B(RATIO_B), .RATIO_C(RATIO_C), .RATIO_D(RATIO_D)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (start_ok),
    .en       (active),
    .code     (rate_q),
    .base_tick(base_tick)
  );

  preset_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (start_ok),
    .load_val(preset),
    .step    (base_tick),
    .ovf     (ovf)
  );

  dwell_counter #(.W(DWELL_W)) u_dwell (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (start_ok),
    .limit_in(dwell),
    .ovf     (ovf),
    .fire    (fire)
  );

  always_comb begin
    running_d = running_q;
    error_d   = error_q;
    rate_d    = rate_q;
    if (stop) begin
      running_d = 1'b0;
    end else if (start_ok) begin
      running_d = 1'b1;
      error_d   = 1'b0;
      rate_d    = rate_sel;
    end else if (start_bad) begin
      error_d = 1'b1;
    end
    tick_d   = ovf;
    strobe_d = fire;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      running_q <= 1'b0;
      error_q   <= 1'b0;
      rate_q    <= '0;
      tick_q    <= 1'b0;
      strobe_q  <= 1'b0;
    end else begin
      running_q <= running_d;
      error_q   <= error_d;
      rate_q    <= rate_d;
      tick_q    <= tick_d;
      strobe_q  <= strobe_d;
    end
  end

  assign tick_o    = tick_q;
  assign strobe_o  = strobe_q;
  assign running_o = running_q;
  assign error_o   = error_q;
endmodule

// File: rtl/sample_pacer_chk.sv
module sample_pacer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] preset,
  input logic        start,
  input logic        stop,
  input logic        tick_o,
  input logic        strobe_o,
  input logic        running_o,
  input logic        error_o
);
  // R3
  tick_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> running_o);

  // R5
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> tick_o);

  // R6
  bad_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop && !running_o && !preset[15]) |=> (error_o && !running_o));

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!running_o && !tick_o && !strobe_o));

  // R8
  hold_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !stop) |=> running_o);

  // R9
  good_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop && !running_o && preset[15]) |=> (running_o && !error_o));
endmodule

bind sample_pacer sample_pacer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .preset   (preset),
  .start    (start),
  .stop     (stop),
  .tick_o   (tick_o),
  .strobe_o (strobe_o),
  .running_o(running_o),
  .error_o  (error_o)
);

// File: tb/sample_pacer_bench.sv
module sample_pacer_bench;
  logic        clk;
  logic        rst_n;
  logic [2:0]  rate_sel;
  logic [15:0] preset;
  logic [15:0] dwell;
  logic        start;
  logic        stop;
  logic        tick_o, strobe_o, running_o, error_o;

  int checks = 0;
  int errors = 0;
  bit exp_err = 1'b0;

  typedef struct {
    bit    run;
    bit    tick;
    bit    strobe;
    bit    err;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  sample_pacer u_sample_pacer (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .preset(preset),
    .dwell(dwell), .start(start), .stop(stop), .tick_o(tick_o),
    .strobe_o(strobe_o), .running_o(running_o), .error_o(error_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int ratio_of(input logic [2:0] code);
    case (code)
      3'd1:    return 1;
      3'd2:    return 10;
      3'd3:    return 100;
      3'd4:    return 1000;
      default: return 0;
    endcase
  endfunction

  // Monitor: pops one expected item per cycle, 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (running_o !== e.run || tick_o !== e.tick ||
          strobe_o !== e.strobe || error_o !== e.err) begin
        errors++;
        $display("FAIL %s: got run=%b tick=%b strobe=%b err=%b exp run=%b tick=%b strobe=%b err=%b",
                 e.tag, running_o, tick_o, strobe_o, error_o,
                 e.run, e.tick, e.strobe, e.err);
      end
    end
  end

  // Driver: one run from a start pulse; pushes a prediction for every cycle.
  task automatic run_cfg(input logic [2:0] code, input logic [15:0] pre,
                         input logic [15:0] dw, input int ncyc,
                         input int stop_at, input bit poke, input string tag);
    int ratio, per, dwe;
    bit valid;
    ratio = ratio_of(code);
    valid = pre[15] && (stop_at != 0);
    per   = ratio * (65536 - int'(pre));
    dwe   = (dw == 0) ? 1 : int'(dw);
    @(negedge clk);
    rate_sel = code; preset = pre; dwell = dw; start = 1'b1;
    stop = (stop_at == 0);
    if (stop_at != 0) exp_err = !pre[15];
    for (int k = 0; k <= ncyc + 1; k++) begin
      exp_t e;
      e.run    = valid && (k < stop_at);
      e.tick   = e.run && (ratio != 0) && (k > 0) && (k % per == 0);
      e.strobe = e.tick && ((k / per) % dwe == 0);
      e.err    = exp_err;
      e.tag    = tag;
      sb_q.push_back(e);
    end
    for (int k = 1; k <= ncyc + 1; k++) begin
      @(negedge clk);
      stop  = (k == stop_at);
      start = 1'b0;
      if (poke && k == 3) begin
        // R8: new settings and a start while running must be ignored
        start = 1'b1; preset = 16'hFFFF; dwell = 16'd1; rate_sel = 3'd1;
      end
    end
    @(negedge clk);
    stop = 1'b0; start = 1'b0;
    while (sb_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; stop = 1'b0;
    rate_sel = 3'd0; preset = 16'd0; dwell = 16'd0;
    repeat (3) @(negedge clk);
    checks++;
    if ({running_o, tick_o, strobe_o, error_o} !== 4'b0) begin
      errors++;
      $display("FAIL R1: outputs in reset %b expected 0000",
               {running_o, tick_o, strobe_o, error_o});
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if ({running_o, tick_o, strobe_o, error_o} !== 4'b0) begin
      errors++;
      $display("FAIL R1: outputs after reset %b expected 0000",
               {running_o, tick_o, strobe_o, error_o});
    end

    run_cfg(3'd1, -16'sd3, 16'd2, 30, 30, 1'b0, "R3 R4 R5 div1 p-3 d2");
    run_cfg(3'd1, 16'hFFFF, 16'd1, 12, 12, 1'b0, "R4 p-1 back-to-back");
    run_cfg(3'd2, -16'sd2, 16'd0, 65, 65, 1'b0, "R2 R5 div10 dwell0");
    run_cfg(3'd3, 16'hFFFF, 16'd3, 700, 700, 1'b0, "R2 div100 d3");
    run_cfg(3'd4, -16'sd2, 16'd1, 4100, 4100, 1'b0, "R2 div1000");
    run_cfg(3'd0, -16'sd2, 16'd1, 20, 20, 1'b0, "R2 code0 no ticks");
    run_cfg(3'd6, -16'sd2, 16'd1, 20, 20, 1'b0, "R2 code6 no ticks");
    run_cfg(3'd1, 16'd0, 16'd1, 6, 6, 1'b0, "R6 preset zero");
    run_cfg(3'd1, 16'd5, 16'd1, 6, 6, 1'b0, "R6 preset positive");
    run_cfg(3'd1, -16'sd4, 16'd1, 16, 16, 1'b0, "R9 error cleared");
    run_cfg(3'd1, -16'sd4, 16'd1, 20, 12, 1'b0, "R7 stop on overflow edge");
    run_cfg(3'd1, -16'sd4, 16'd1, 10, 0, 1'b0, "R7 stop beats start");
    run_cfg(3'd1, -16'sd5, 16'd2, 40, 40, 1'b1, "R8 ignore while running");
    run_cfg(3'd1, 16'h8000, 16'd1, 32770, 32770, 1'b0, "R3 most negative preset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule